// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a small single-port synchronous memory whose data bus never idles when traffic changes direction. Each clock can start a read or a write. The block registers the address and command on the rising edge. The data for that operation moves exactly two edges later, for both directions, so a write can follow a read, or a read can follow a write, on consecutive cycles. For synthesis the shared data bus is split into three signals: a write-data input, a read-data output, and a drive-enable output. The drive-enable output is what a pad or a tristate wrapper uses.

A burst engine lets one loaded address produce four consecutive words. The low two address bits then step either by modulo-4 addition or by XOR with a count. A stall pin freezes the whole block. Three chip selects gate the start of a new operation. Per-lane write strobes limit which bytes a write changes. An asynchronous output enable can silence the bus at any moment.

The data slot has a fixed latency, so the block has no valid/ready handshake and cannot apply back-pressure. The only flow control is the stall pin, and the attached controller must hold its own pipeline while stall is high. The depth must be a power of two of at least 4.

Top module: `zbt_sram`

## Requirements
- R1: A read whose command is captured at edge k drives its word on `rdata`, with `rdata_oe` high, from just after edge k+1, so the word is valid when the controller samples at edge k+2.
- R2: A write whose command is captured at edge k takes `wdata` and `byte_we` as they stand at edge k+2.
- R3: Reads and writes may alternate on every cycle. A read issued one cycle after a write to the same address returns the newly written lanes.
- R4: While `stall` is 1, no command is captured, no pending write is committed, and `rdata`, `rdata_oe` and the pipeline hold their values.
- R5: A new operation is loaded only when `advance`=0, `sel0`=1, `sel1`=1 and `sel2_n`=0. A load cycle with any select inactive issues nothing and ends the burst, but operations already in flight still complete.
- R6: `rdata_oe` is low in the data slot of a write, and in the data slot of a cycle that issued nothing.
- R7: `out_en`=0 forces `rdata_oe` to 0 at once, without waiting for a clock edge.
- R8: With `burst_mode`=0 latched at the load, each `advance`=1 cycle issues the loaded address with its low two bits replaced by (start + n) mod 4, where n is the number of advances so far. The high bits are unchanged, n wraps after 3, and the command type is the one that was loaded.
- R9: With `burst_mode`=1 latched at the load, each advance replaces the low two bits with start XOR n.
- R10: An `advance`=1 cycle issues nothing if no burst is live, either after reset or after a deselecting load.
- R11: A write changes only the lanes i with `byte_we[i]`=1. Lane i is `wdata[8i+7:8i]`.
- R12: After reset, `rdata_oe` is 0 and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | 1 freezes every register |
| sel0 | input | 1 | Chip select, active high |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| advance | input | 1 | 1 steps the burst, 0 loads a new address |
| is_write | input | 1 | 1 write, 0 read, taken on a load |
| burst_mode | input | 1 | 0 modulo-4 order, 1 XOR order, taken on a load |
| addr | input | AW | Word address, AW = log2(DEPTH) |
| byte_we | input | LANES | Per-lane write strobes for the data slot |
| wdata | input | LANES*LANE_W | Write data for the data slot |
| out_en | input | 1 | Asynchronous output enable |
| rdata | output | LANES*LANE_W | Read data |
| rdata_oe | output | 1 | Drive enable for the data bus |

## Verification
The hardest case to reach is a read that lands on the edge where a write to the same address commits. The read must receive the incoming strobed lanes, and the memory contents for every other lane. Directed write-then-read pairs on one address drive this case with mixed strobes. A long random phase repeats it by drawing addresses from the small array, and stalls and deselects fall between the two operations. Burst wrap-around and advances after a deselect are also placed by hand, because random stimulus seldom chains four advances.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

  typedef enum logic {
    ORDER_ADD = 1'b0,
    ORDER_XOR = 1'b1
  } burst_order_e;

  // low two address bits for burst step n from a starting offset
  function automatic logic [1:0] burst_lane(input logic [1:0] start,
                                            input logic [1:0] n,
                                            input burst_order_e order);
    return (order == ORDER_XOR) ? (start ^ n) : (start + n);
  endfunction

endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq
  import zbt_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          sel_ok,
  input  logic          advance,
  input  logic          is_write,
  input  logic          burst_mode,
  input  logic [AW-1:0] addr,
  output logic          s1_valid,
  output logic          s1_wr,
  output logic [AW-1:0] s1_addr
);

  logic          live_q;
  logic          wr_q;
  burst_order_e  mode_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;

  logic          load;
  logic          step;
  logic [1:0]    next_cnt;
  logic [AW-1:0] issue_addr;

  assign load     = !advance && sel_ok;
  assign step     = advance && live_q;
  assign next_cnt = cnt_q + 2'd1;

  always_comb begin
    if (load) issue_addr = addr;
    else      issue_addr = {base_q[AW-1:2], burst_lane(base_q[1:0], next_cnt, mode_q)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= 1'b0;
      wr_q     <= 1'b0;
      mode_q   <= ORDER_ADD;
      base_q   <= '0;
      cnt_q    <= '0;
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
    end else if (!stall) begin
      if (!advance) begin
        live_q <= sel_ok;
        if (sel_ok) begin
          base_q <= addr;
          cnt_q  <= '0;
          wr_q   <= is_write;
          mode_q <= burst_order_e'(burst_mode);
        end
      end else if (live_q) begin
        cnt_q <= next_cnt;
      end
      s1_valid <= load || step;
      s1_wr    <= load ? is_write : wr_q;
      s1_addr  <= issue_addr;
    end
  end

  p_deselect_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !advance && !sel_ok) |=> !s1_valid);

  p_advance_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && advance && !live_q) |=> !s1_valid);

  p_linear_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && advance && live_q && mode_q == ORDER_ADD)
      |=> (s1_valid && s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1
           && s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));

endmodule

// File: rtl/zbt_lane_store.sv
module zbt_lane_store #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             rd_req,
  input  logic [AW-1:0]    rd_addr,
  input  logic             wr_req,
  input  logic [AW-1:0]    wr_addr,
  input  logic [LANES-1:0] byte_we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    dout,
  output logic             dout_valid
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] wr_val;
    logic [LANE_W-1:0] rd_val;
    logic [LANE_W-1:0] lane_q;
    logic              lane_wr;
    logic              bypass;

    assign wr_val  = wdata[g*LANE_W +: LANE_W];
    assign lane_wr = wr_req && byte_we[g];
    // a write committing on this edge feeds a read of the same word
    assign bypass  = lane_wr && (wr_addr == rd_addr);
    assign rd_val  = bypass ? wr_val : cells[rd_addr];

    always_ff @(posedge clk) begin
      if (!stall && lane_wr) cells[wr_addr] <= wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lane_q <= '0;
      else if (!stall && rd_req) lane_q <= rd_val;
    end

    assign dout[g*LANE_W +: LANE_W] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dout_valid <= 1'b0;
    else if (!stall) dout_valid <= rd_req;
  end

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(dout) && $stable(dout_valid)));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             sel0,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             advance,
  input  logic             is_write,
  input  logic             burst_mode,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] byte_we,
  input  logic [DW-1:0]    wdata,
  input  logic             out_en,
  output logic [DW-1:0]    rdata,
  output logic             rdata_oe
);

  logic          sel_ok;
  logic          s1_valid, s1_wr;
  logic [AW-1:0] s1_addr;
  logic          s2_valid, s2_wr;
  logic [AW-1:0] s2_addr;
  logic          rd_valid;

  assign sel_ok = sel0 && sel1 && !sel2_n;

  zbt_burst_seq #(.AW(AW)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .sel_ok     (sel_ok),
    .advance    (advance),
    .is_write   (is_write),
    .burst_mode (burst_mode),
    .addr       (addr),
    .s1_valid   (s1_valid),
    .s1_wr      (s1_wr),
    .s1_addr    (s1_addr)
  );

  // second pipeline stage: the command whose data slot is the next edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_wr    <= 1'b0;
      s2_addr  <= '0;
    end else if (!stall) begin
      s2_valid <= s1_valid;
      s2_wr    <= s1_wr;
      s2_addr  <= s1_addr;
    end
  end

  zbt_lane_store #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .rd_req     (s1_valid && !s1_wr),
    .rd_addr    (s1_addr),
    .wr_req     (s2_valid && s2_wr),
    .wr_addr    (s2_addr),
    .byte_we    (byte_we),
    .wdata      (wdata),
    .dout       (rdata),
    .dout_valid (rd_valid)
  );

  assign rdata_oe = out_en && rd_valid;

  p_read_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && s1_valid && !s1_wr) |=> rd_valid);

  p_bus_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !(s1_valid && !s1_wr)) |=> !rdata_oe);

endmodule

// File: tb/test_zbt_sram.sv
`timescale 1ns/1ps
module test_zbt_sram;
  localparam int DEPTH = 64;
  localparam int NL    = 4;
  localparam int LW    = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int DW    = NL * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0, sel0 = 1'b0, sel1 = 1'b0, sel2_n = 1'b1;
  logic advance = 1'b0, is_write = 1'b0, burst_mode = 1'b0, out_en = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] byte_we = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  zbt_sram #(.DEPTH(DEPTH), .LANES(NL), .LANE_W(LW)) i_zbt_sram (
    .clk(clk), .rst_n(rst_n), .stall(stall), .sel0(sel0), .sel1(sel1),
    .sel2_n(sel2_n), .advance(advance), .is_write(is_write),
    .burst_mode(burst_mode), .addr(addr), .byte_we(byte_we), .wdata(wdata),
    .out_en(out_en), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // reference state built from the requirements
  logic [DW-1:0] mmem [DEPTH];
  bit m1_v, m1_w, m2_v, m2_w, m_dv;
  logic [AW-1:0] m1_a, m2_a;
  logic [DW-1:0] m_dout;
  bit b_live, b_wr, b_mode;
  logic [AW-1:0] b_base;
  logic [1:0] b_cnt;

  function automatic logic [1:0] order(input logic [1:0] s, input logic [1:0] n, input bit m);
    return m ? (s ^ n) : 2'((s + n) % 4);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit st, input bit [2:0] sels, input bit adv, input bit wr,
                      input bit mode, input logic [AW-1:0] a, input logic [NL-1:0] be,
                      input logic [DW-1:0] wd, input bit oe, input string req);
    bit iv, iw;
    logic [AW-1:0] ia;
    stall = st; {sel0, sel1, sel2_n} = sels; advance = adv; is_write = wr;
    burst_mode = mode; addr = a; byte_we = be; wdata = wd; out_en = oe;
    #1;
    chk(rdata_oe == (m_dv && oe), req, DW'(rdata_oe), DW'(m_dv && oe));
    if (!st) begin
      if (m2_v && m2_w)
        for (int i = 0; i < NL; i++)
          if (be[i]) mmem[m2_a][i*LW +: LW] = wd[i*LW +: LW];
      if (m1_v && !m1_w) m_dout = mmem[m1_a];
      m_dv = m1_v && !m1_w;
      m2_v = m1_v; m2_w = m1_w; m2_a = m1_a;
      iv = 1'b0; iw = 1'b0; ia = a;
      if (!adv) begin
        b_live = (sels == 3'b110);
        if (b_live) begin
          b_base = a; b_cnt = 2'd0; b_wr = wr; b_mode = mode;
          iv = 1'b1; iw = wr;
        end
      end else if (b_live) begin
        b_cnt = b_cnt + 2'd1;
        ia = {b_base[AW-1:2], order(b_base[1:0], b_cnt, b_mode)};
        iv = 1'b1; iw = b_wr;
      end
      m1_v = iv; m1_w = iw; m1_a = ia;
    end
    @(posedge clk); @(negedge clk);
    chk(rdata_oe == (m_dv && oe), req, DW'(rdata_oe), DW'(m_dv && oe));
    if (m_dv && oe) chk(rdata == m_dout, req, rdata, m_dout);
  endtask

  task automatic load(input bit wr, input logic [AW-1:0] a, input bit mode, input string req);
    step(1'b0, 3'b110, 1'b0, wr, mode, a, NL'($urandom), DW'($urandom), 1'b1, req);
  endtask

  task automatic adv(input string req);
    step(1'b0, 3'b110, 1'b1, 1'b0, 1'b0, '0, NL'($urandom), DW'($urandom), 1'b1, req);
  endtask

  task automatic idle(input string req);
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, '0, NL'($urandom), DW'($urandom), 1'b1, req);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1921));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rdata_oe == 1'b0, "R12", DW'(rdata_oe), '0);
    rst_n = 1'b1;
    // R10: advance with no live burst after reset
    adv("R10"); adv("R10"); adv("R10");
    // R2: fill every word with full-lane writes
    for (int i = 0; i < DEPTH; i++)
      step(1'b0, 3'b110, 1'b0, 1'b1, 1'b0, AW'(i), '1, DW'($urandom), 1'b1, "R2");
    idle("R2"); idle("R2");
    for (int i = 0; i < DEPTH; i++) load(1'b0, AW'(i), 1'b0, "R1");
    idle("R1"); idle("R1");
    // R3: alternate write and read on one word, every cycle
    for (int i = 0; i < 6; i++) load(i % 2 == 0, AW'(5), 1'b0, "R3");
    idle("R3"); idle("R3");
    // R11: partial strobes, then read the word back at once
    step(1'b0, 3'b110, 1'b0, 1'b1, 1'b0, AW'(9), '0, '0, 1'b1, "R11");
    step(1'b0, 3'b110, 1'b0, 1'b0, 1'b0, AW'(9), '0, '0, 1'b1, "R11");
    step(1'b0, 3'b110, 1'b0, 1'b0, 1'b0, AW'(9), 4'b0101, 32'hA1B2C3D4, 1'b1, "R11");
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, '0, 4'b1010, 32'h11223344, 1'b1, "R11");
    idle("R11"); idle("R11");
    // R8: modulo-4 read burst from offset 2, with wrap
    load(1'b0, AW'(6), 1'b0, "R8");
    for (int i = 0; i < 5; i++) adv("R8");
    idle("R8"); idle("R8");
    // R9: XOR write burst from offset 1, then XOR read burst from offset 3
    load(1'b1, AW'(13), 1'b1, "R9");
    for (int i = 0; i < 3; i++) adv("R9");
    load(1'b0, AW'(15), 1'b1, "R9");
    for (int i = 0; i < 3; i++) adv("R9");
    idle("R9"); idle("R9");
    // R5: each select inactive in turn; a read in flight still completes
    load(1'b0, AW'(20), 1'b0, "R5");
    step(1'b0, 3'b010, 1'b0, 1'b0, 1'b0, AW'(21), '0, '0, 1'b1, "R5");
    step(1'b0, 3'b100, 1'b0, 1'b0, 1'b0, AW'(22), '0, '0, 1'b1, "R5");
    step(1'b0, 3'b111, 1'b0, 1'b0, 1'b0, AW'(23), '0, '0, 1'b1, "R5");
    // R10: advance after a deselect
    adv("R10"); adv("R10");
    // R6: read then write then read: bus off in the write slot
    load(1'b0, AW'(30), 1'b0, "R6");
    load(1'b1, AW'(31), 1'b0, "R6");
    load(1'b0, AW'(30), 1'b0, "R6");
    idle("R6"); idle("R6");
    // R4: stall with a read and a write in flight, data changing meanwhile
    load(1'b1, AW'(40), 1'b0, "R4");
    load(1'b0, AW'(41), 1'b0, "R4");
    for (int i = 0; i < 4; i++)
      step(1'b1, 3'b110, 1'b0, 1'b1, 1'b0, AW'(50), '1, DW'($urandom), 1'b1, "R4");
    load(1'b0, AW'(40), 1'b0, "R4");
    idle("R4"); idle("R4");
    // R7: output enable low while read data is due
    load(1'b0, AW'(3), 1'b0, "R7");
    load(1'b0, AW'(4), 1'b0, "R7");
    step(1'b0, 3'b110, 1'b0, 1'b0, 1'b0, AW'(7), '0, '0, 1'b0, "R7");
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b0, "R7");
    idle("R7"); idle("R7");
    // R1: random mix of every control
    for (int i = 0; i < 3000; i++) begin
      bit [2:0] s;
      s = ($urandom % 10 == 0) ? 3'($urandom) : 3'b110;
      step(($urandom % 10) == 0, s, ($urandom % 5) < 2, 1'($urandom), 1'($urandom),
           AW'($urandom), NL'($urandom), DW'($urandom), ($urandom % 10) != 0, "R1");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule